// File: doc/BRIEF.md
# Integer-N Synthesizer Divider and Phase-Frequency Detector Core

This block is the clocked digital heart of an integer-N clock synthesizer. It takes a reference waveform and a feedback waveform, both sampled by the system clock. Each waveform passes through its own programmable divider. The reference divider is 14 bits wide and the feedback divider is 13 bits wide. A three-state phase-frequency detector compares the two divided edges and produces pump-up and pump-down enables for an external charge pump. The charge pump, loop filter and oscillator are outside this block.

A lock indicator rises once the detector has seen several consecutive comparison cycles in which the one-sided pulse stays narrow. It falls as soon as a pulse grows too wide. There are two ways to power the core down: a hardware enable pin, and a software bit held in a configuration register that a separate serial loader fills. Either one raises a high-impedance request to the pump and holds the dividers, the detector and the lock logic clear. The divider values also come from that register file and are simply inputs here.

Top module: `pll_core`

## Requirements
- R1: After reset, with the core enabled, pumpUp, pumpDn, pumpHiZ and lockDet are all 0.
- R2: A rising edge of refIn is one that is high at a clock edge after being low at the previous one. The reference divider emits one pulse for every refDivCfg-th such edge, counted from power-up or reset. A value of 0 behaves as 1.
- R3: The feedback divider does the same for fbIn with fbDivCfg, so a value of 1 passes every feedback edge through. A value of 0 also behaves as 1.
- R4: pumpUp goes high in the second clock after the clock edge that samples a qualifying reference edge. It stays high until the detector resets.
- R5: pumpDn behaves the same way for a qualifying feedback edge.
- R6: When pumpUp and pumpDn are both high, both return low on the next clock, so they overlap for exactly one cycle when no new divided edge arrives in that cycle.
- R7: lockDet rises in the clock after the third consecutive detector reset whose preceding one-sided pulse lasted at most 1 clock.
- R8: lockDet falls in the clock after the second consecutive cycle in which only one of pumpUp and pumpDn is high.
- R9: pumpHiZ is 1 in the same cycle that chipEn is low or swPowerDown is high. While pumpHiZ is 1, pumpUp and pumpDn are 0.
- R10: While powered down, the divider counts, the detector state and the lock logic are held clear. lockDet is 0 from the first clock of power-down. After power-up, both divider counts start again from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| refIn | input | 1 | Reference waveform, sampled by clk |
| fbIn | input | 1 | Feedback waveform, sampled by clk |
| chipEn | input | 1 | Hardware enable; low powers the core down |
| swPowerDown | input | 1 | Software power-down bit from the register file |
| refDivCfg | input | 14 | Reference divide ratio (0 acts as 1) |
| fbDivCfg | input | 13 | Feedback divide ratio (0 acts as 1) |
| pumpUp | output | 1 | Charge-pump source enable |
| pumpDn | output | 1 | Charge-pump sink enable |
| pumpHiZ | output | 1 | Request for a high-impedance pump output |
| lockDet | output | 1 | Digital lock indicator |

## Verification
A wrong divider count shows up as a missing or extra pump pulse two clocks after the offending input edge. The bench pins down the exact cycle of each enable, so a miscount is caught at the first divided edge after it. A detector flop that fails to clear leaves the overlap wider than one cycle on the very next clock. A lock counter that holds stale history makes lockDet rise or fall one comparison cycle early or late, which shows at the clock right after the deciding detector reset. Power-down state that leaks through appears either as pump enables while pumpHiZ is high, or as a divided edge arriving one input edge too soon after power-up.

// File: rtl/pll_pkg.sv
package pll_pkg;

  // Strobes from the divider datapath to the control section
  typedef struct packed {
    logic refTick;
    logic fbTick;
  } divStrobe_t;

  // Strobes from the control section to the divider datapath
  typedef struct packed {
    logic holdDiv;
  } pllCtrl_t;

endpackage

// File: rtl/pll_divider.sv
module pll_divider #(
  parameter int CNT_W = 14
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             hold,
  input  logic             waveIn,
  input  logic [CNT_W-1:0] limit,
  output logic             tick
);

  logic             prevQ;
  logic [CNT_W-1:0] cntQ;
  logic             tickQ;
  logic [CNT_W-1:0] limEff;
  logic             riseEdge;

  assign limEff   = (limit == '0) ? CNT_W'(1) : limit;
  assign riseEdge = waveIn & ~prevQ;
  assign tick     = tickQ;

  always_ff @(posedge clk) begin
    if (!rstN) prevQ <= 1'b0;
    else       prevQ <= waveIn;
  end

  always_ff @(posedge clk) begin
    if (!rstN || hold) begin
      cntQ  <= '0;
      tickQ <= 1'b0;
    end else if (riseEdge) begin
      if (cntQ >= limEff - CNT_W'(1)) begin
        cntQ  <= '0;
        tickQ <= 1'b1;
      end else begin
        cntQ  <= cntQ + CNT_W'(1);
        tickQ <= 1'b0;
      end
    end else begin
      tickQ <= 1'b0;
    end
  end

  // R2 / R3: an edge needs a low sample before it, so ticks never repeat back to back
  p_tick_gap_r2: assert property (@(posedge clk) disable iff (!rstN) tickQ |=> !tickQ);
  // R10: a held divider emits nothing
  p_tick_hold_r10: assert property (@(posedge clk) disable iff (!rstN) hold |=> !tickQ);

endmodule

// File: rtl/pll_datapath.sv
module pll_datapath
  import pll_pkg::*;
#(
  parameter int REF_W = 14,
  parameter int FB_W  = 13
) (
  input  logic             clk,
  input  logic             rstN,
  input  pllCtrl_t         ctrl,
  input  logic             refIn,
  input  logic             fbIn,
  input  logic [REF_W-1:0] refDivCfg,
  input  logic [FB_W-1:0]  fbDivCfg,
  output divStrobe_t       strb
);

  logic refTick;
  logic fbTick;

  pll_divider #(.CNT_W(REF_W)) refDiv_i (
    .clk    (clk),
    .rstN   (rstN),
    .hold   (ctrl.holdDiv),
    .waveIn (refIn),
    .limit  (refDivCfg),
    .tick   (refTick)
  );

  pll_divider #(.CNT_W(FB_W)) fbDiv_i (
    .clk    (clk),
    .rstN   (rstN),
    .hold   (ctrl.holdDiv),
    .waveIn (fbIn),
    .limit  (fbDivCfg),
    .tick   (fbTick)
  );

  assign strb.refTick = refTick;
  assign strb.fbTick  = fbTick;

endmodule

// File: rtl/pll_control.sv
module pll_control
  import pll_pkg::*;
#(
  parameter int LOCK_CYCLES = 3,
  parameter int ERR_TOL     = 1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       chipEn,
  input  logic       swPowerDown,
  input  divStrobe_t strb,
  output pllCtrl_t   ctrl,
  output logic       pumpUp,
  output logic       pumpDn,
  output logic       pumpHiZ,
  output logic       lockDet
);

  localparam int GOOD_W = $clog2(LOCK_CYCLES + 1);
  localparam int ERR_W  = $clog2(ERR_TOL + 2);

  logic              active;
  logic              upQ;
  logic              dnQ;
  logic              bothQ;
  logic              oneSided;
  logic [GOOD_W-1:0] goodCnt;
  logic [ERR_W-1:0]  errCnt;
  logic              lockQ;

  assign active       = chipEn & ~swPowerDown;
  assign ctrl.holdDiv = ~active;
  assign bothQ        = upQ & dnQ;
  assign oneSided     = upQ ^ dnQ;

  // Three-state detector: two edge-set flops with a shared clear
  always_ff @(posedge clk) begin
    if (!rstN || !active) begin
      upQ <= 1'b0;
      dnQ <= 1'b0;
    end else if (bothQ) begin
      upQ <= strb.refTick;
      dnQ <= strb.fbTick;
    end else begin
      upQ <= upQ | strb.refTick;
      dnQ <= dnQ | strb.fbTick;
    end
  end

  // Lock qualification on the width of the one-sided pulse
  always_ff @(posedge clk) begin
    if (!rstN || !active) begin
      goodCnt <= '0;
      errCnt  <= '0;
      lockQ   <= 1'b0;
    end else if (bothQ) begin
      errCnt <= '0;
      if (errCnt <= ERR_W'(ERR_TOL)) begin
        if (goodCnt != GOOD_W'(LOCK_CYCLES)) goodCnt <= goodCnt + GOOD_W'(1);
        lockQ <= (goodCnt >= GOOD_W'(LOCK_CYCLES - 1));
      end else begin
        goodCnt <= '0;
        lockQ   <= 1'b0;
      end
    end else if (oneSided) begin
      if (errCnt != ERR_W'(ERR_TOL + 1)) errCnt <= errCnt + ERR_W'(1);
      if (errCnt >= ERR_W'(ERR_TOL)) begin
        goodCnt <= '0;
        lockQ   <= 1'b0;
      end
    end
  end

  assign pumpUp  = upQ & active;
  assign pumpDn  = dnQ & active;
  assign pumpHiZ = ~active;
  assign lockDet = lockQ;

  // R4: a divided reference edge sets the up flop on the following clock
  p_up_set_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strb.refTick && active) |=> upQ);
  // R5: same for the feedback side
  p_dn_set_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strb.fbTick && active) |=> dnQ);
  // R6: overlap clears after one cycle unless both edges arrive again
  p_overlap_one_r6: assert property (@(posedge clk) disable iff (!rstN)
    (bothQ && !(strb.refTick && strb.fbTick)) |=> !bothQ);
  // R7: lock only rises right after a detector reset
  p_lock_rise_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(lockQ) |-> $past(bothQ));
  // R9: a high-impedance request masks both enables
  p_hiz_mask_r9: assert property (@(posedge clk) disable iff (!rstN)
    pumpHiZ |-> (!pumpUp && !pumpDn));
  // R10: lock is low from the first clock of power-down
  p_lock_pd_r10: assert property (@(posedge clk) disable iff (!rstN)
    !active |=> !lockQ);

endmodule

// File: rtl/pll_core.sv
module pll_core
  import pll_pkg::*;
#(
  parameter int REF_W       = 14,
  parameter int FB_W        = 13,
  parameter int LOCK_CYCLES = 3,
  parameter int ERR_TOL     = 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             refIn,
  input  logic             fbIn,
  input  logic             chipEn,
  input  logic             swPowerDown,
  input  logic [REF_W-1:0] refDivCfg,
  input  logic [FB_W-1:0]  fbDivCfg,
  output logic             pumpUp,
  output logic             pumpDn,
  output logic             pumpHiZ,
  output logic             lockDet
);

  divStrobe_t strb;
  pllCtrl_t   ctrl;

  pll_datapath #(.REF_W(REF_W), .FB_W(FB_W)) datapath_i (
    .clk       (clk),
    .rstN      (rstN),
    .ctrl      (ctrl),
    .refIn     (refIn),
    .fbIn      (fbIn),
    .refDivCfg (refDivCfg),
    .fbDivCfg  (fbDivCfg),
    .strb      (strb)
  );

  pll_control #(.LOCK_CYCLES(LOCK_CYCLES), .ERR_TOL(ERR_TOL)) control_i (
    .clk         (clk),
    .rstN        (rstN),
    .chipEn      (chipEn),
    .swPowerDown (swPowerDown),
    .strb        (strb),
    .ctrl        (ctrl),
    .pumpUp      (pumpUp),
    .pumpDn      (pumpDn),
    .pumpHiZ     (pumpHiZ),
    .lockDet     (lockDet)
  );

endmodule

// File: tb/pll_core_tb.sv
module pll_core_tb_top;

  localparam int SIG_UP = 0, SIG_DN = 1, SIG_HIZ = 2, SIG_LOCK = 3;

  typedef struct {
    int    at;
    int    sig;
    bit    val;
    string tag;
  } expItem_t;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        refIn = 1'b0;
  logic        fbIn = 1'b0;
  logic        chipEn = 1'b1;
  logic        swPowerDown = 1'b0;
  logic [13:0] refDivCfg = 14'd1;
  logic [12:0] fbDivCfg = 13'd1;
  logic        pumpUp, pumpDn, pumpHiZ, lockDet;

  expItem_t sb[$];
  int  cyc = 0;
  int  nCompared = 0;
  int  nMismatch = 0;
  bit  finished = 1'b0;

  always #10 clk = ~clk;

  pll_core dut_i (
    .clk(clk), .rstN(rstN), .refIn(refIn), .fbIn(fbIn),
    .chipEn(chipEn), .swPowerDown(swPowerDown),
    .refDivCfg(refDivCfg), .fbDivCfg(fbDivCfg),
    .pumpUp(pumpUp), .pumpDn(pumpDn), .pumpHiZ(pumpHiZ), .lockDet(lockDet)
  );

  function automatic bit sigVal(int s);
    case (s)
      SIG_UP:  return pumpUp;
      SIG_DN:  return pumpDn;
      SIG_HIZ: return pumpHiZ;
      default: return lockDet;
    endcase
  endfunction

  function automatic string sigName(int s);
    case (s)
      SIG_UP:  return "pumpUp";
      SIG_DN:  return "pumpDn";
      SIG_HIZ: return "pumpHiZ";
      default: return "lockDet";
    endcase
  endfunction

  function automatic void expectAt(int at, int s, bit v, string tag);
    expItem_t e;
    e.at = at; e.sig = s; e.val = v; e.tag = tag;
    sb.push_back(e);
  endfunction

  // Monitor: counts posedges and samples mid high phase
  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      #5;
      for (int i = sb.size() - 1; i >= 0; i--) begin
        if (sb[i].at <= cyc) begin
          bit got;
          got = sigVal(sb[i].sig);
          nCompared++;
          if (sb[i].at < cyc || got !== sb[i].val) begin
            nMismatch++;
            $display("FAIL %s: %s at cycle %0d actual=%0b expected=%0b",
                     sb[i].tag, sigName(sb[i].sig), cyc, got, sb[i].val);
          end
          sb.delete(i);
        end
      end
    end
  end

  // Driver helpers: all calls start and end at a negedge
  task automatic setIn(bit r, bit f);
    refIn = r; fbIn = f;
    @(negedge clk);
    refIn = 1'b0; fbIn = 1'b0;
    @(negedge clk);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic alignedPulse(string tag, bit lockAfter, bit checkLock);
    int c;
    c = cyc;
    expectAt(c + 2, SIG_UP, 1'b1, tag);
    expectAt(c + 2, SIG_DN, 1'b1, tag);
    expectAt(c + 3, SIG_UP, 1'b0, tag);
    expectAt(c + 3, SIG_DN, 1'b0, tag);
    if (checkLock) expectAt(c + 3, SIG_LOCK, lockAfter, "R7");
    setIn(1'b1, 1'b1);
    idle(3);
  endtask

  // Watchdog
  initial begin
    #(20 * 100000);
    if (!finished) begin
      nMismatch++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCompared, nMismatch);
      $finish;
    end
  end

  initial begin
    int c;
    idle(3);
    rstN = 1'b1;
    // R1: reset state
    c = cyc;
    expectAt(c + 1, SIG_UP, 1'b0, "R1");
    expectAt(c + 1, SIG_DN, 1'b0, "R1");
    expectAt(c + 1, SIG_HIZ, 1'b0, "R1");
    expectAt(c + 1, SIG_LOCK, 1'b0, "R1");
    idle(2);

    // R3 pass-through with R6 single-cycle overlap
    alignedPulse("R6", 1'b0, 1'b0);

    // R4: reference leads by two clocks
    c = cyc;
    expectAt(c + 2, SIG_UP, 1'b1, "R4");
    expectAt(c + 2, SIG_DN, 1'b0, "R4");
    expectAt(c + 3, SIG_UP, 1'b1, "R4");
    expectAt(c + 4, SIG_DN, 1'b1, "R6");
    expectAt(c + 5, SIG_UP, 1'b0, "R6");
    setIn(1'b1, 1'b0);
    setIn(1'b0, 1'b1);
    idle(3);

    // R5: feedback leads by two clocks
    c = cyc;
    expectAt(c + 2, SIG_DN, 1'b1, "R5");
    expectAt(c + 2, SIG_UP, 1'b0, "R5");
    expectAt(c + 3, SIG_DN, 1'b1, "R5");
    expectAt(c + 5, SIG_DN, 1'b0, "R6");
    setIn(1'b0, 1'b1);
    setIn(1'b1, 1'b0);
    idle(3);

    // R7: three aligned comparisons give lock
    alignedPulse("R7", 1'b0, 1'b1);
    alignedPulse("R7", 1'b0, 1'b1);
    alignedPulse("R7", 1'b1, 1'b1);

    // R7: one clock of skew is tolerated
    c = cyc;
    expectAt(c + 2, SIG_UP, 1'b1, "R7");
    expectAt(c + 4, SIG_LOCK, 1'b1, "R7");
    refIn = 1'b1; @(negedge clk);
    refIn = 1'b0; fbIn = 1'b1; @(negedge clk);
    fbIn = 1'b0;
    idle(4);

    // R8: two clocks of skew drop lock
    c = cyc;
    expectAt(c + 3, SIG_LOCK, 1'b1, "R8");
    expectAt(c + 4, SIG_LOCK, 1'b0, "R8");
    setIn(1'b1, 1'b0);
    setIn(1'b0, 1'b1);
    idle(3);

    // Relock, then hardware power-down (R9, R10)
    alignedPulse("R7", 1'b0, 1'b0);
    alignedPulse("R7", 1'b0, 1'b0);
    alignedPulse("R7", 1'b1, 1'b1);
    c = cyc;
    chipEn = 1'b0;
    expectAt(c + 1, SIG_HIZ, 1'b1, "R9");
    expectAt(c + 1, SIG_LOCK, 1'b0, "R10");
    expectAt(c + 3, SIG_UP, 1'b0, "R9");
    idle(1);
    setIn(1'b1, 1'b0);
    idle(2);
    c = cyc;
    chipEn = 1'b1;
    expectAt(c + 1, SIG_HIZ, 1'b0, "R9");
    expectAt(c + 1, SIG_UP, 1'b0, "R10");
    idle(2);

    // R9: software power-down bit
    c = cyc;
    swPowerDown = 1'b1;
    expectAt(c + 1, SIG_HIZ, 1'b1, "R9");
    expectAt(c + 3, SIG_DN, 1'b0, "R9");
    idle(1);
    setIn(1'b0, 1'b1);
    idle(1);
    c = cyc;
    swPowerDown = 1'b0;
    expectAt(c + 1, SIG_HIZ, 1'b0, "R9");
    expectAt(c + 3, SIG_DN, 1'b0, "R10");
    idle(3);

    // R2: divide-by-3 on the reference side
    refDivCfg = 14'd3;
    idle(1);
    for (int k = 0; k < 3; k++) begin
      c = cyc;
      expectAt(c + 2, SIG_UP, (k == 2), "R2");
      setIn(1'b1, 1'b0);
      idle(2);
    end
    setIn(1'b0, 1'b1);
    idle(3);

    // R10: power-down restarts the reference count
    refDivCfg = 14'd2;
    setIn(1'b1, 1'b0);
    chipEn = 1'b0;
    idle(2);
    chipEn = 1'b1;
    idle(1);
    c = cyc;
    expectAt(c + 2, SIG_UP, 1'b0, "R10");
    setIn(1'b1, 1'b0);
    idle(1);
    c = cyc;
    expectAt(c + 2, SIG_UP, 1'b1, "R10");
    setIn(1'b1, 1'b0);
    setIn(1'b0, 1'b1);
    idle(3);

    // R2: zero ratio acts as one
    refDivCfg = 14'd0;
    idle(1);
    c = cyc;
    expectAt(c + 2, SIG_UP, 1'b1, "R2");
    setIn(1'b1, 1'b0);
    setIn(1'b0, 1'b1);
    idle(3);

    // R3: divide-by-2 on the feedback side
    refDivCfg = 14'd1;
    fbDivCfg = 13'd2;
    idle(1);
    c = cyc;
    expectAt(c + 2, SIG_DN, 1'b0, "R3");
    setIn(1'b0, 1'b1);
    idle(1);
    c = cyc;
    expectAt(c + 2, SIG_DN, 1'b1, "R3");
    setIn(1'b0, 1'b1);
    setIn(1'b1, 1'b0);
    idle(4);

    if (sb.size() != 0) begin
      nMismatch++;
      $display("FAIL scoreboard: actual=%0d pending expected=0", sb.size());
    end
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCompared, nMismatch);
    $finish;
  end

endmodule